// File: doc/BRIEF.md
# USB Device Interrupt Status Aggregator

This block gathers the interrupt causes of a USB device controller into one sticky status word and raises a single level interrupt request while any cause is pending. Its inputs are the live control flags of the control endpoint (endpoint 0), the packet-complete flags of the receive and transmit endpoints, a bus-idle level, a resume-signalling level, and one mask bit per source taken from a control register. A mask that is set stops its status bit from ever becoming set. It does not hide a bit that is already pending.

Suspend detection is done inside the block. An idle counter measures how long the bus has been continuously idle, counted in clock cycles derived from `CLK_FREQ_HZ` and `IDLE_TIME_US`. When the threshold is exceeded, the block raises the suspend cause once and enters a suspended state. While suspended, resume signalling raises the resume cause and ends the suspended state. Software reads the status word through a simple register port and clears causes by writing ones. A zero written to a position leaves that position as it was.

Top module: `usb_irq_status`

## Requirements
- R1: `irq_o` is high exactly when the status word is non-zero.
- R2: The status bit layout is bit 0 control endpoint, bit 1 receive, bit 2 transmit, bit 3 suspend, bit 4 resume. `rd_data_o` bits 7..5 always read as zero.
- R3: When `wr_en_i` is high, each status bit whose `wr_data_i` position is 1 is cleared. Positions written with 0 keep their value.
- R4: While a source's mask input is high, its status bit cannot become set. Changing a mask does not clear a pending bit.
- R5: Bit 0 is set by any of these: `ep0_out_rdy_i` rising, `ep0_in_rdy_i` falling, `ep0_data_end_i` falling, `ep0_setup_end_i` rising, or `ep0_sent_stall_i` rising. The opposite edges do not set it.
- R6: Bit 1 is set when `rx_done_i` rises. Bit 2 is set when `tx_done_i` rises.
- R7: Bit 3 is set after `bus_idle_i` has been sampled high on IDLE_CYCLES+1 consecutive clocks, where IDLE_CYCLES = CLK_FREQ_HZ/1e6 * IDLE_TIME_US. It is not set at IDLE_CYCLES samples.
- R8: The suspend cause fires only once per idle period. It can fire again only after `bus_idle_i` has been low for at least one cycle.
- R9: `suspended_o` goes high in the same clock that sets the suspend cause. It goes low when resume signalling is seen while suspended, and on reset.
- R10: Bit 4 is set only when `resume_sig_i` is high while the block is suspended. Resume signalling outside suspend has no effect.
- R11: The single `mask_susp_i` input governs both bit 3 and bit 4. The suspended state is tracked regardless of that mask.
- R12: If a set event and a write-one clear hit the same bit in one cycle, the bit ends up set.
- R13: Status bits and `suspended_o` change on the clock edge that samples the causing input. Status is visible one cycle after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ep0_out_rdy_i | input | 1 | Control endpoint OUT-packet-ready flag |
| ep0_in_rdy_i | input | 1 | Control endpoint IN-packet-ready flag |
| ep0_data_end_i | input | 1 | Control endpoint data-end flag |
| ep0_setup_end_i | input | 1 | Control endpoint setup-end flag |
| ep0_sent_stall_i | input | 1 | Control endpoint stall-sent flag |
| rx_done_i | input | 1 | Receive endpoint packet-complete flag |
| tx_done_i | input | 1 | Transmit endpoint packet-complete flag |
| bus_idle_i | input | 1 | Bus idle level |
| resume_sig_i | input | 1 | Resume signalling detected on the bus |
| mask_ep0_i | input | 1 | Mask for bit 0 |
| mask_rx_i | input | 1 | Mask for bit 1 |
| mask_tx_i | input | 1 | Mask for bit 2 |
| mask_susp_i | input | 1 | Mask for bits 3 and 4 |
| wr_en_i | input | 1 | Write strobe for write-one-to-clear |
| wr_data_i | input | DATA_W | Clear pattern, one per status bit |
| rd_data_o | output | DATA_W | Status word, zero-extended |
| irq_o | output | 1 | Level interrupt request |
| suspended_o | output | 1 | Suspended state |

## Verification
The embedded assertions check the following on every cycle:
- a written one clears a bit unless a set event arrives in the same cycle, in which case the set takes precedence;
- status holds when there is no write and no set event;
- a masked control-endpoint bit stays clear;
- the idle detector fires at most once per idle period and always enters suspend when it fires;
- resume signalling while suspended always ends suspend;
- the resume bit only rises after a suspended cycle.

Some behaviours can only be shown by the bench scenarios:
- the exact idle threshold, with no suspend at IDLE_CYCLES samples and suspend at IDLE_CYCLES+1;
- the polarity of each of the five control-endpoint edges;
- the shared suspend/resume mask;
- resume signalling ignored outside suspend.

The bench also compares the full status word, the interrupt and the suspended state each cycle against a reference model during long random runs.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned NUM_SRC  = 5;
  localparam int unsigned IDX_EP0  = 0;
  localparam int unsigned IDX_RX   = 1;
  localparam int unsigned IDX_TX   = 2;
  localparam int unsigned IDX_SUSP = 3;
  localparam int unsigned IDX_RES  = 4;

  localparam int unsigned EP0_FLAGS = 5;
  // flag order {stall, setup_end, data_end, in_rdy, out_rdy}; 1 = rising edge
  localparam logic [EP0_FLAGS-1:0] EP0_RISE = 5'b11001;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/usb_irq_edge.sv
module usb_irq_edge #(
  parameter int unsigned      WIDTH     = 2,
  parameter logic [WIDTH-1:0] RISE_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] edge_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_edge
    if (RISE_MASK[g]) begin : g_rise
      assign edge_o[g] = lvl_i[g] & ~prev_q[g];
    end else begin : g_fall
      assign edge_o[g] = ~lvl_i[g] & prev_q[g];
    end
  end
endmodule

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
  parameter int unsigned IDLE_CYCLES = 144000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_idle_i,
  input  logic resume_i,
  output logic fire_o,
  output logic resume_ev_o,
  output logic suspended_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_CYCLES + 2);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             susp_q;

  // saturates one past LIMIT so fire_o pulses once per idle period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!bus_idle_i)   cnt_q <= '0;
    else if (cnt_q <= LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign fire_o      = bus_idle_i && (cnt_q == LIMIT);
  assign resume_ev_o = susp_q & resume_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) susp_q <= 1'b0;
    else         susp_q <= fire_o | (susp_q & ~resume_i);
  end

  assign suspended_o = susp_q;

  // R8
  single_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
  // R9
  susp_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> suspended_o);
  // R9
  susp_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspended_o && resume_i && !fire_o) |=> !suspended_o);
endmodule

// File: rtl/usb_irq_sticky.sv
module usb_irq_sticky #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q & ~clr_i) | set_i;
  end

  assign status_o = st_q;

  // R3
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((st_q & $past(clr_i & ~set_i)) == '0));
  // R12
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((st_q & $past(set_i)) == $past(set_i)));
  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(st_q));
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
  import usb_irq_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ  = 48_000_000,
  parameter int unsigned IDLE_TIME_US = 3000,
  parameter int unsigned DATA_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ep0_out_rdy_i,
  input  logic              ep0_in_rdy_i,
  input  logic              ep0_data_end_i,
  input  logic              ep0_setup_end_i,
  input  logic              ep0_sent_stall_i,
  input  logic              rx_done_i,
  input  logic              tx_done_i,
  input  logic              bus_idle_i,
  input  logic              resume_sig_i,
  input  logic              mask_ep0_i,
  input  logic              mask_rx_i,
  input  logic              mask_tx_i,
  input  logic              mask_susp_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              suspended_o
);
  localparam int unsigned IDLE_CYCLES = (CLK_FREQ_HZ / 1_000_000) * IDLE_TIME_US;

  logic [EP0_FLAGS-1:0] ep0_lvl, ep0_edge;
  logic [1:0]           dat_edge;
  logic                 fire, resume_ev;
  src_vec_t             event_vec, mask_vec, set_vec, clr_vec, status;

  assign ep0_lvl = {ep0_sent_stall_i, ep0_setup_end_i, ep0_data_end_i,
                    ep0_in_rdy_i, ep0_out_rdy_i};

  usb_irq_edge #(.WIDTH(EP0_FLAGS), .RISE_MASK(EP0_RISE)) u_ep0_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(ep0_lvl), .edge_o(ep0_edge)
  );

  usb_irq_edge #(.WIDTH(2), .RISE_MASK(2'b11)) u_dat_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i({tx_done_i, rx_done_i}), .edge_o(dat_edge)
  );

  usb_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_idle_i (bus_idle_i),
    .resume_i   (resume_sig_i),
    .fire_o     (fire),
    .resume_ev_o(resume_ev),
    .suspended_o(suspended_o)
  );

  always_comb begin
    event_vec           = '0;
    event_vec[IDX_EP0]  = |ep0_edge;
    event_vec[IDX_RX]   = dat_edge[0];
    event_vec[IDX_TX]   = dat_edge[1];
    event_vec[IDX_SUSP] = fire;
    event_vec[IDX_RES]  = resume_ev;
    mask_vec            = '0;
    mask_vec[IDX_EP0]   = mask_ep0_i;
    mask_vec[IDX_RX]    = mask_rx_i;
    mask_vec[IDX_TX]    = mask_tx_i;
    mask_vec[IDX_SUSP]  = mask_susp_i;
    mask_vec[IDX_RES]   = mask_susp_i;
  end

  // masks gate setting only, never a pending bit
  assign set_vec = event_vec & ~mask_vec;
  assign clr_vec = wr_en_i ? wr_data_i[NUM_SRC-1:0] : '0;

  usb_irq_sticky #(.WIDTH(NUM_SRC)) u_sticky (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .status_o(status)
  );

  assign rd_data_o = DATA_W'(status);
  assign irq_o     = |status;

  // R4
  mask_ep0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_ep0_i && !status[IDX_EP0]) |=> !status[IDX_EP0]);
  // R10
  resume_only_susp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status[IDX_RES]) |-> $past(suspended_o));
endmodule

// File: tb/usb_irq_status_tb.sv
module usb_irq_status_tb;
  localparam int T = 20;  // IDLE_CYCLES for 1 MHz, 20 us

  logic clk = 1'b0, rst_ni = 1'b0;
  logic out_rdy = 0, in_rdy = 0, data_end = 0, setup_end = 0, stall = 0;
  logic rx = 0, tx = 0, idle = 0, res = 0;
  logic m_ep0 = 0, m_rx = 0, m_tx = 0, m_sr = 0, wr = 0;
  logic [7:0] wd = '0, rd;
  logic irq, susp;

  int n_tests = 0, n_fail = 0;

  // reference state
  logic [4:0] e_st = '0;
  logic       e_susp = 0;
  int         e_cnt = 0;
  logic [6:0] p_lvl = '0;

  always #4 clk = ~clk;

  usb_irq_status #(.CLK_FREQ_HZ(1_000_000), .IDLE_TIME_US(T), .DATA_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ep0_out_rdy_i(out_rdy), .ep0_in_rdy_i(in_rdy), .ep0_data_end_i(data_end),
    .ep0_setup_end_i(setup_end), .ep0_sent_stall_i(stall),
    .rx_done_i(rx), .tx_done_i(tx), .bus_idle_i(idle), .resume_sig_i(res),
    .mask_ep0_i(m_ep0), .mask_rx_i(m_rx), .mask_tx_i(m_tx), .mask_susp_i(m_sr),
    .wr_en_i(wr), .wr_data_i(wd), .rd_data_o(rd), .irq_o(irq), .suspended_o(susp)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model advances with the inputs applied this cycle
  task automatic model_step();
    logic [6:0] lvl;
    logic ev0, fire, rev;
    logic [4:0] set, clr;
    lvl  = {tx, rx, stall, setup_end, data_end, in_rdy, out_rdy};
    ev0  = (lvl[0] & ~p_lvl[0]) | (~lvl[1] & p_lvl[1]) | (~lvl[2] & p_lvl[2]) |
           (lvl[3] & ~p_lvl[3]) | (lvl[4] & ~p_lvl[4]);
    fire = idle && (e_cnt == T);
    rev  = e_susp && res;
    set  = {rev & ~m_sr, fire & ~m_sr, lvl[6] & ~p_lvl[6] & ~m_tx,
            lvl[5] & ~p_lvl[5] & ~m_rx, ev0 & ~m_ep0};
    clr  = wr ? wd[4:0] : 5'b0;
    e_st   = (e_st & ~clr) | set;
    e_susp = fire | (e_susp & ~res);
    e_cnt  = !idle ? 0 : (e_cnt <= T ? e_cnt + 1 : e_cnt);
    p_lvl  = lvl;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check("R13 status vs model", {24'h0, rd}, {27'h0, e_st});
    check("R1 irq", {31'h0, irq}, {31'h0, |e_st});
    check("R9 suspended", {31'h0, susp}, {31'h0, e_susp});
    wr = 0;
  endtask

  task automatic clear_all();
    wr = 1; wd = 8'hFF; cyc();
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset rd", {24'h0, rd}, 32'h0);
    check("R1 reset irq", {31'h0, irq}, 32'h0);
    check("R9 reset susp", {31'h0, susp}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R5 each edge polarity
    out_rdy = 1; cyc(); check("R5 out_rdy rise", {24'h0, rd}, 32'h01);
    wr = 1; wd = 8'h01; cyc(); check("R3 w1c", {24'h0, rd}, 32'h0);
    out_rdy = 0; cyc(); check("R5 out_rdy fall ignored", {24'h0, rd}, 32'h0);
    in_rdy = 1; cyc(); check("R5 in_rdy rise ignored", {24'h0, rd}, 32'h0);
    in_rdy = 0; cyc(); check("R5 in_rdy fall", {24'h0, rd}, 32'h01);
    clear_all();
    data_end = 1; cyc(); check("R5 data_end rise ignored", {24'h0, rd}, 32'h0);
    data_end = 0; cyc(); check("R5 data_end fall", {24'h0, rd}, 32'h01);
    clear_all();
    setup_end = 1; cyc(); check("R5 setup_end rise", {24'h0, rd}, 32'h01);
    setup_end = 0; clear_all();
    stall = 1; cyc(); check("R5 stall rise", {24'h0, rd}, 32'h01);
    stall = 0; clear_all();
    check("R5 stall fall ignored", {24'h0, rd}, 32'h0);

    // R4 / R6
    m_rx = 1; rx = 1; cyc(); check("R4 masked rx", {24'h0, rd}, 32'h0);
    m_rx = 0; rx = 0; cyc(); rx = 1; cyc(); check("R6 rx rise", {24'h0, rd}, 32'h02);
    m_rx = 1; cyc(); check("R4 mask keeps pending", {24'h0, rd}, 32'h02);
    m_rx = 0;
    wr = 1; wd = 8'hE0; cyc(); check("R2 upper write no effect", {24'h0, rd}, 32'h02);
    wr = 1; wd = 8'h00; cyc(); check("R3 zero write keeps", {24'h0, rd}, 32'h02);
    tx = 1; wr = 1; wd = 8'h04; cyc(); check("R12 set wins", {24'h0, rd}, 32'h06);
    rx = 0; tx = 0; clear_all();

    // R7 / R8 / R9 / R10
    idle = 1;
    for (int i = 0; i < T; i++) cyc();
    check("R7 not yet at threshold", {24'h0, rd}, 32'h0);
    cyc(); check("R7 suspend set", {24'h0, rd}, 32'h08);
    check("R9 suspended entered", {31'h0, susp}, 32'h1);
    clear_all();
    for (int i = 0; i < 2 * T; i++) cyc();
    check("R8 no refire", {24'h0, rd}, 32'h0);
    res = 1; cyc(); check("R10 resume set", {24'h0, rd}, 32'h10);
    check("R9 suspended left", {31'h0, susp}, 32'h0);
    clear_all(); cyc();
    check("R10 resume ignored when awake", {24'h0, rd}, 32'h0);
    res = 0;

    // R11 shared mask
    m_sr = 1; idle = 0; cyc(); idle = 1;
    for (int i = 0; i <= T; i++) cyc();
    check("R11 suspend masked", {24'h0, rd}, 32'h0);
    check("R11 state tracked", {31'h0, susp}, 32'h1);
    res = 1; cyc(); check("R11 resume masked", {24'h0, rd}, 32'h0);
    res = 0; m_sr = 0; idle = 0; clear_all();

    // random run, fixed seed
    void'($urandom(32'h5A17));
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[4:0] == 0) idle = ~idle;
      res = (r[8:5] == 0);
      if (r[12:9] == 0) {out_rdy, in_rdy, data_end, setup_end, stall, rx, tx} = r[19:13];
      if (r[24:20] == 0) {m_ep0, m_rx, m_tx, m_sr} = r[28:25];
      wr = (r[31:29] == 0);
      wd = 8'($urandom);
      cyc();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule